// File: doc/BRIEF.md
# UART Receive Byte Queue with Overrun Detection

This block buffers received characters for a 16550-style serial receiver. A deserializer hands it one byte per `push` strobe. The register-read logic takes the oldest byte from `pop_data` and strobes `pop` to consume it.

When `fifo_en` is high, bytes go into a 16-entry circular queue. When it is low, a single holding register is used instead. For the line status logic the block reports:
- the queue occupancy,
- a data-ready flag,
- a sticky overrun flag.

It also gives the interrupt logic a receive-data-available condition. In queue mode this condition compares the occupancy with a trigger level selected by two control bits. A clear strobe from the FIFO control logic empties the queue in one cycle.

The two modes treat overflow differently:
- **Queue mode:** a byte pushed into a full queue is thrown away. The stored bytes and the count are left alone, and the overrun flag is raised.
- **Holding-register mode:** a byte that arrives before the previous one was read overwrites it and raises the overrun flag.

Every strobe acts on the rising clock edge. Outputs show the state after that edge.

Top module: `uart_rx_fifo`

## Requirements
- R1: In queue mode each push stores its byte behind earlier ones. `pop_data` always shows the oldest stored byte. A push raises `count` by one and a pop lowers it by one. A push and a pop in the same cycle leave `count` unchanged and advance the head of the queue.
- R2: A push while `count` equals 16 does not store the byte. `count` stays at 16 and the 16 stored bytes pop out unchanged and in order. Fullness is judged before any pop in the same cycle.
- R3: In queue mode, a push while `count` equals 16 sets `overrun` at the next edge.
- R4: In holding mode (`fifo_en` = 0), a push that arrives while `data_ready` is 1 and no pop is in the same cycle sets `overrun`. The new byte replaces the held byte in any case.
- R5: An `lsr_read` strobe clears `overrun`. If a new overrun event happens in the same cycle, the flag stays set.
- R6: In queue mode, `rx_avail` is 1 exactly when `count` is at least the trigger level. The level comes from `trig_sel`: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R7: In holding mode, `rx_avail` equals `data_ready`.
- R8: In queue mode, `data_ready` is set after any accepted push. It clears when a pop removes the last byte, so it is 1 exactly when `count` is nonzero.
- R9: `fifo_clr` makes `count` 0 and `data_ready` 0 (in queue mode) at the next edge. It overrides a push or pop in the same cycle, does not change `overrun`, and does not touch the holding register.
- R10: A pop while the queue is empty is ignored: `count` stays 0 and `overrun` is unchanged.
- R11: Read and write positions wrap after the last slot. Byte order is kept across runs that pass slot 15.
- R12: After reset, `count`, `data_ready`, `overrun` and `rx_avail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects holding-register mode |
| trig_sel | input | 2 | Trigger level code for `rx_avail` |
| fifo_clr | input | 1 | Empties the queue |
| push | input | 1 | A received byte is offered on `push_data` |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Consumes the byte shown on `pop_data` |
| pop_data | output | 8 | Oldest byte available to the reader |
| lsr_read | input | 1 | Line status was read; clears `overrun` |
| count | output | 5 | Queue occupancy, 0 to 16 |
| data_ready | output | 1 | At least one byte is waiting |
| overrun | output | 1 | Sticky overrun error |
| rx_avail | output | 1 | Receive-data-available condition |

## Verification
A write position that steps into a full queue overwrites the oldest stored byte. That shows up as a wrong `pop_data` once the reader drains down to that slot, which may be up to 16 pops later. The bench therefore drains full queues completely and compares every byte.

A count that runs past 16, or falls below zero on an empty pop, distorts `count` and `rx_avail` at the very next edge. A data-ready flag that drifts from the count is visible on the cycle the last byte leaves. A lost overrun event is visible on the `overrun` output one cycle after the offending push.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Trigger level selected by the two-bit code (1, 4, 8, 14 bytes).
  function automatic int unsigned rx_trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Occupancy compared against the selected threshold.
  function automatic logic rx_meets_trigger(input int unsigned occ,
                                            input logic [1:0] sel);
    return occ >= rx_trig_level(sel);
  endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_req,
  input  logic                         rd_req,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         nonempty,
  output logic                         drop
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q, head_nx, tail_nx;
  logic              full, empty, do_wr, do_rd;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign do_wr = wr_req && !clr && !full;
  assign do_rd = rd_req && !clr && !empty;
  assign drop  = wr_req && !clr && full;

  // Pointer advance: natural wrap for a power-of-two depth, compare otherwise.
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2_wrap
      assign head_nx = head_q + 1'b1;
      assign tail_nx = tail_q + 1'b1;
    end else begin : g_cmp_wrap
      assign head_nx = (head_q == LAST_PTR) ? '0 : head_q + 1'b1;
      assign tail_nx = (tail_q == LAST_PTR) ? '0 : tail_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_wr) mem[head_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      count    <= '0;
      nonempty <= 1'b0;
    end else if (clr) begin
      head_q   <= '0;
      tail_q   <= '0;
      count    <= '0;
      nonempty <= 1'b0;
    end else begin
      if (do_wr) head_q <= head_nx;
      if (do_rd) tail_q <= tail_nx;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (do_wr)
        nonempty <= 1'b1;
      else if (do_rd && count == CNT_W'(1))
        nonempty <= 1'b0;
    end
  end

  assign rd_data = mem[tail_q];

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              clobber
);
  // A byte is lost only when the previous one is still unread.
  assign clobber = wr && valid && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      if (wr) begin
        data  <= wr_data;
        valid <= 1'b1;
      end else if (rd) begin
        valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rx_line_status.sv
module rx_line_status #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic [1:0]                 trig_sel,
  input  logic [$clog2(DEPTH+1)-1:0] occ,
  input  logic                       hold_valid,
  input  logic                       ovr_event,
  input  logic                       lsr_read,
  output logic                       overrun,
  output logic                       rx_avail
);
  import uart_rx_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      overrun <= 1'b0;
    else if (ovr_event)
      overrun <= 1'b1;
    else if (lsr_read)
      overrun <= 1'b0;
  end

  always_comb begin
    if (fifo_en) rx_avail = rx_meets_trigger(32'(occ), trig_sel);
    else         rx_avail = hold_valid;
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic [1:0]                 trig_sel,
  input  logic                       fifo_clr,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          pop_data,
  input  logic                       lsr_read,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       data_ready,
  output logic                       overrun,
  output logic                       rx_avail
);
  logic [DATA_W-1:0] q_data, h_data;
  logic              q_nonempty, q_drop;
  logic              h_valid, h_clobber;
  logic              ovr_event;

  rx_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (fifo_clr),
    .wr_req   (push && fifo_en),
    .rd_req   (pop && fifo_en),
    .wr_data  (push_data),
    .rd_data  (q_data),
    .count    (count),
    .nonempty (q_nonempty),
    .drop     (q_drop)
  );

  rx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (push && !fifo_en),
    .rd      (pop && !fifo_en),
    .wr_data (push_data),
    .data    (h_data),
    .valid   (h_valid),
    .clobber (h_clobber)
  );

  assign ovr_event = fifo_en ? q_drop : h_clobber;

  rx_line_status #(.DEPTH(DEPTH)) u_lsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .trig_sel   (trig_sel),
    .occ        (count),
    .hold_valid (h_valid),
    .ovr_event  (ovr_event),
    .lsr_read   (lsr_read),
    .overrun    (overrun),
    .rx_avail   (rx_avail)
  );

  assign data_ready = fifo_en ? q_nonempty : h_valid;
  assign pop_data   = fifo_en ? q_data : h_data;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_en,
  input logic                       fifo_clr,
  input logic                       push,
  input logic                       pop,
  input logic                       lsr_read,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       data_ready,
  input logic                       overrun,
  input logic                       ovr_event
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH); // R2

  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && push && !pop && !fifo_clr && 32'(count) == DEPTH
    |=> 32'(count) == DEPTH); // R2

  AST_FULL_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && push && !fifo_clr && 32'(count) == DEPTH |=> overrun); // R3

  AST_HOLD_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && push && data_ready && !pop |=> overrun); // R4

  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_read && !ovr_event |=> !overrun); // R5

  AST_DR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> data_ready == (count != '0)); // R8

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> count == '0); // R9

  AST_CLR_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr && !ovr_event && !lsr_read |=> $stable(overrun)); // R9

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && pop && !push && count == '0 |=> count == '0); // R10

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .fifo_clr   (fifo_clr),
  .push       (push),
  .pop        (pop),
  .lsr_read   (lsr_read),
  .count      (count),
  .data_ready (data_ready),
  .overrun    (overrun),
  .ovr_event  (ovr_event)
);

// File: tb/tb_uart_rx_fifo.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       fifo_clr = 1'b0, push = 1'b0, pop = 1'b0, lsr_read = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic [7:0] pop_data;
  logic [4:0] count;
  logic       data_ready, overrun, rx_avail;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .fifo_clr(fifo_clr), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .lsr_read(lsr_read), .count(count),
    .data_ready(data_ready), .overrun(overrun), .rx_avail(rx_avail)
  );

  typedef struct packed {
    logic       en;
    logic [1:0] trig;
    logic       clr, pu, po, lsr;
    logic [7:0] din;
    logic [4:0] e_cnt;
    logic       e_dr, e_ovr, e_rda;
    logic [7:0] e_dout;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    // en trig clr pu po lsr din    cnt dr ovr rda dout
    '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1, 5'd1, 1'b1, 1'b0, 1'b0, 8'hA1}, // R1 R6
    '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA2, 5'd2, 1'b1, 1'b0, 1'b0, 8'hA1}, // R1
    '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA3, 5'd3, 1'b1, 1'b0, 1'b0, 8'hA1}, // R6
    '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA4, 5'd4, 1'b1, 1'b0, 1'b1, 8'hA1}, // R6
    '{1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 5'd3, 1'b1, 1'b0, 1'b0, 8'hA2}, // R1
    '{1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd3, 1'b1, 1'b0, 1'b1, 8'hA2}, // R6
    '{1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 5'd3, 1'b1, 1'b0, 1'b1, 8'hA3}, // R1
    '{1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R9
    '{1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 5'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R10
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hB1, 5'd0, 1'b1, 1'b0, 1'b1, 8'hB1}, // R7
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hB2, 5'd0, 1'b1, 1'b1, 1'b1, 8'hB2}, // R4
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 5'd0, 1'b1, 1'b0, 1'b1, 8'hB2}, // R5
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 5'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R7
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hB3, 5'd0, 1'b1, 1'b0, 1'b1, 8'hB3}, // R4
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hB4, 5'd0, 1'b1, 1'b0, 1'b1, 8'hB4}  // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One edge of stimulus; outputs are sampled 2 ns after the edge.
  task automatic step(input logic en, input logic [1:0] tg, input logic c,
                      input logic pu, input logic po, input logic l,
                      input logic [7:0] d);
    @(negedge clk);
    fifo_en = en; trig_sel = tg; fifo_clr = c; push = pu; pop = po;
    lsr_read = l; push_data = d;
    @(posedge clk);
    #2;
    fifo_clr = 1'b0; push = 1'b0; pop = 1'b0; lsr_read = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R12 count", count, 0);
    chk("R12 data_ready", data_ready, 0);
    chk("R12 overrun", overrun, 0);
    chk("R12 rx_avail", rx_avail, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].en, VEC[i].trig, VEC[i].clr, VEC[i].pu, VEC[i].po,
           VEC[i].lsr, VEC[i].din);
      chk($sformatf("vec%0d count", i), count, VEC[i].e_cnt);
      chk($sformatf("vec%0d data_ready", i), data_ready, VEC[i].e_dr);
      chk($sformatf("vec%0d overrun", i), overrun, VEC[i].e_ovr);
      chk($sformatf("vec%0d rx_avail", i), rx_avail, VEC[i].e_rda);
      if (VEC[i].e_dr) chk($sformatf("vec%0d pop_data", i), pop_data, VEC[i].e_dout);
    end

    // R6 threshold 14 and R2/R3 full behaviour
    step(1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10 + 8'(i));
      if (i == 12) chk("R6 below 14", rx_avail, 0);
      if (i == 13) chk("R6 at 14", rx_avail, 1);
    end
    chk("R1 count full", count, 16);
    step(1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 8'hEE);
    chk("R2 count saturates", count, 16);
    chk("R3 overrun on full push", overrun, 1);
    step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R5 lsr_read clears", overrun, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R2 contents kept", pop_data, 8'h10 + 8'(i));
      step(1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    end
    chk("R8 data_ready after last pop", data_ready, 0);
    chk("R8 count empty", count, 0);

    // R11 wrap across slot 15
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 10; i++)
        step(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'(r * 16 + i + 8'h40));
      for (int i = 0; i < 10; i++) begin
        chk("R11 order across wrap", pop_data, r * 16 + i + 8'h40);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
      end
    end

    // R5 same-cycle overrun wins over lsr_read
    for (int i = 0; i < 16; i++)
      step(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'(i));
    step(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF);
    chk("R5 new event wins", overrun, 1);
    // R9 clear with push, overrun kept
    step(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h77);
    chk("R9 count cleared", count, 0);
    chk("R9 data_ready cleared", data_ready, 0);
    chk("R9 overrun unchanged", overrun, 1);
    // R10 pop on empty
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R10 empty pop count", count, 0);
    chk("R10 empty pop overrun", overrun, 1);
    // R9 holding register untouched by clear (held B4 from table)
    step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R9 hold kept", pop_data, 8'hB4);
    chk("R7 hold avail", rx_avail, 1);

    finish_run();
  end
endmodule